// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a synchronous serial slave that lets an external controller read and write a bank of byte-wide configuration registers. The controller lowers the chip select, clocks in one instruction byte, and then moves one to four data bytes in the same cycle. The instruction byte carries the transfer direction, the byte count and the start address. The port keeps its own address pointer and steps it after each data byte, so a multi-byte transfer touches neighbouring registers.

The serial clock, chip select and input data are brought into the system clock domain by a synchronizer. Edges of the serial clock are detected there. Input bits are captured on rising edges of the serial clock, and read data is launched on falling edges.

Register 0 controls the port itself:
- One bit picks a three-wire mode. In this mode read data leaves on the shared data line, with its output enable raised.
- A second bit picks least-significant-bit-first order. This order also makes the address pointer count upward; the default most-significant-bit-first order makes it count downward.
- A third bit triggers a soft reset that clears the whole bank.

The bank contents are offered in parallel to the rest of the chip.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset every register bit is 0. `sdo`, `sdio_out` and `sdio_oe` are 0. The port starts in four-wire mode with most-significant-bit-first order.
- R2: The instruction byte is decoded once it has been fully assembled. Bit 7 set means read and bit 7 clear means write. Bits 6:5 hold the byte count minus one. Bits 4:0 hold the start address. In most-significant-bit-first order the first serial bit is bit 7. In least-significant-bit-first order the first serial bit is bit 0.
- R3: A write data byte is stored into the register at the current address on the eighth rising serial clock edge of that byte. Data bits follow the same order as the instruction.
- R4: In most-significant-bit-first order (register 0 bit 6 clear), the address pointer decrements after each data byte and wraps from 0 to 31.
- R5: In least-significant-bit-first order (register 0 bit 6 set), the address pointer increments after each data byte and wraps from 31 to 0.
- R6: In a read, every data bit is presented after a falling serial clock edge so that the controller can sample it on the next rising edge. The first bit appears after the falling edge that follows the last instruction bit. The bit order of a read is the order used for writes.
- R7: In four-wire mode (register 0 bit 7 clear), read data appears on `sdo`. `sdio_oe` stays 0 and `sdio_out` stays 0.
- R8: In three-wire mode (register 0 bit 7 set), read data appears on `sdio_out`. `sdio_oe` is 1 from the first data bit until chip select rises, and is 0 once chip select is high. `sdo` stays 0.
- R9: A change to register 0 bit 6 or bit 7 takes effect only after chip select is released. The remaining bytes of the transfer that carried the change still use the old order and the old pin mode.
- R10: Writing a byte with bit 5 set to register 0 clears every register, including the mode bits. Bit 5 of register 0 always reads back as 0.
- R11: Raising chip select ends the transfer at once and resets the bit counter. A partially shifted byte is discarded. Data bytes beyond the instruction's byte count are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from the controller, active low |
| sclk | input | 1 | Serial clock from the controller |
| sdio_in | input | 1 | Serial data into the port (shared line in three-wire mode) |
| sdio_out | output | 1 | Read data onto the shared line in three-wire mode |
| sdio_oe | output | 1 | Output enable for the shared data line |
| sdo | output | 1 | Read data in four-wire mode |
| cfg_q | output | 256 | Register bank contents, register i in bits 8i+7:8i |

## Verification
The bench goes after three corner cases: address wrap in both step directions, a chip-select abort in the middle of a byte, and extra bytes clocked past the byte count. A pointer that wraps or steps the wrong way corrupts an unrelated register. A bit counter that is not cleared on abort would commit a half byte or misframe the next instruction.

The bench also writes register 0 in the middle of a transfer and checks where the following byte lands. A port that switched mode at once would store that byte at the wrong address, in the wrong bit order.

Reads are run in both pin modes. They check that data stays on the selected pin, that the enable follows chip select, and that the soft reset leaves no bit set. A port that drove both pins, or kept the enable high after release, would contend with the controller on the shared line.

// File: rtl/cfg_sp_pkg.sv
package cfg_sp_pkg;
   localparam int unsigned BYTE_W    = 8;
   // control bit positions inside register 0
   localparam int unsigned CTL_BIDIR = 7;
   localparam int unsigned CTL_LSB   = 6;
   localparam int unsigned CTL_SRST  = 5;

   typedef enum logic [1:0] {
      PH_INSTR = 2'd0,
      PH_DATA  = 2'd1,
      PH_DONE  = 2'd2
   } phase_e;
endpackage

// File: rtl/cfg_sp_sync.sv
module cfg_sp_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg <= {stg[STAGES-2:0], d};
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_sp_regbank.sv
module cfg_sp_regbank
   import cfg_sp_pkg::*;
#(
   parameter int unsigned AW = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [AW-1:0]              wr_addr,
   input  logic [BYTE_W-1:0]          wr_data,
   input  logic [AW-1:0]              rd_addr,
   output logic [BYTE_W-1:0]          rd_data,
   output logic [(BYTE_W<<AW)-1:0]    bank
);
   localparam int unsigned NREG = 1 << AW;

   logic srst;
   assign srst = wr_en && (wr_addr == '0) && wr_data[CTL_SRST];

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         localparam logic [BYTE_W-1:0] KEEP =
            (i == 0) ? ~(BYTE_W'(1) << CTL_SRST) : {BYTE_W{1'b1}};
         logic [BYTE_W-1:0] r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r <= '0;
            end else if (srst) begin
               r <= '0;
            end else if (wr_en && (wr_addr == AW'(i))) begin
               r <= wr_data & KEEP;
            end
         end

         assign bank[i*BYTE_W +: BYTE_W] = r;

         // R3
         byte_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_addr == AW'(i)) && !srst) |=> (r == ($past(wr_data) & KEEP)));
      end
   endgenerate

   assign rd_data = bank[rd_addr*BYTE_W +: BYTE_W];

   // R10
   soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (bank == '0));
endmodule

// File: rtl/cfg_sp_engine.sv
module cfg_sp_engine
   import cfg_sp_pkg::*;
#(
   parameter int unsigned CNT_W = 2,
   parameter int unsigned AW    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sclk_s,
   input  logic              sdi_s,
   input  logic              ctl_bidir,
   input  logic              ctl_lsb,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              wr_en,
   output logic [AW-1:0]     wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic [AW-1:0]     rd_addr,
   output logic              out_bit,
   output logic              oe,
   output logic              bidir_mode
);
   localparam int unsigned LW = CNT_W + 1;
   localparam logic [AW-1:0] A_ONE = AW'(1);
   localparam logic [2:0] LAST_BIT = 3'd7;

   phase_e            phase;
   logic              sclk_d;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] tx_q;
   logic [BYTE_W-1:0] byte_in;
   logic [2:0]        bitcnt;
   logic [LW-1:0]     left_q;
   logic [AW-1:0]     addr_q;
   logic [AW-1:0]     addr_step;
   logic              rw_q;
   logic              lsb_act;
   logic              bidir_act;
   logic              rise;
   logic              fall;

   function automatic logic pick(input logic [BYTE_W-1:0] b,
                                 input logic [2:0] idx,
                                 input logic lsb);
      return lsb ? b[idx] : b[3'(BYTE_W-1) - idx];
   endfunction

   assign rise      = sclk_s && !sclk_d && !cs_s;
   assign fall      = !sclk_s && sclk_d && !cs_s;
   assign byte_in   = lsb_act ? {sdi_s, shreg[BYTE_W-1:1]} : {shreg[BYTE_W-2:0], sdi_s};
   assign addr_step = lsb_act ? addr_q + A_ONE : addr_q - A_ONE;

   assign wr_en      = rise && (phase == PH_DATA) && !rw_q && (bitcnt == LAST_BIT);
   assign wr_addr    = addr_q;
   assign wr_data    = byte_in;
   assign rd_addr    = addr_q;
   assign bidir_mode = bidir_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_INSTR;
         sclk_d    <= 1'b0;
         shreg     <= '0;
         tx_q      <= '0;
         bitcnt    <= '0;
         left_q    <= '0;
         addr_q    <= '0;
         rw_q      <= 1'b0;
         lsb_act   <= 1'b0;
         bidir_act <= 1'b0;
         out_bit   <= 1'b0;
         oe        <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         if (cs_s) begin
            phase     <= PH_INSTR;
            bitcnt    <= '0;
            oe        <= 1'b0;
            out_bit   <= 1'b0;
            lsb_act   <= ctl_lsb;
            bidir_act <= ctl_bidir;
         end else begin
            if (rise && (phase != PH_DONE)) begin
               shreg  <= byte_in;
               bitcnt <= bitcnt + 3'd1;
               if (bitcnt == LAST_BIT) begin
                  if (phase == PH_INSTR) begin
                     rw_q   <= byte_in[BYTE_W-1];
                     left_q <= LW'(byte_in[BYTE_W-2 -: CNT_W]) + LW'(1);
                     addr_q <= byte_in[AW-1:0];
                     phase  <= PH_DATA;
                  end else begin
                     addr_q <= addr_step;
                     left_q <= left_q - LW'(1);
                     if (left_q == LW'(1)) begin
                        phase <= PH_DONE;
                     end
                  end
               end
            end
            if (fall && (phase == PH_DATA) && rw_q) begin
               oe <= bidir_act;
               if (bitcnt == 3'd0) begin
                  tx_q    <= rd_data;
                  out_bit <= pick(rd_data, 3'd0, lsb_act);
               end else begin
                  out_bit <= pick(tx_q, bitcnt, lsb_act);
               end
            end
         end
      end
   end

   // R9
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> (cs_s || ($stable(lsb_act) && $stable(bidir_act))));

   // R8
   oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !oe);

   // R7
   oe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bidir_act |-> !oe);

   // R11
   count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA) |-> (left_q != '0));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
   import cfg_sp_pkg::*;
#(
   parameter int unsigned CNT_W       = 2,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned AW         = BYTE_W - 1 - CNT_W,
   localparam int unsigned NREG       = 1 << AW
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   input  logic                     sclk,
   input  logic                     sdio_in,
   output logic                     sdio_out,
   output logic                     sdio_oe,
   output logic                     sdo,
   output logic [NREG*BYTE_W-1:0]   cfg_q
);
   generate
      if (CNT_W < 1 || CNT_W > 3) begin : g_bad_cnt
         $error("CNT_W must lie in 1..3");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              cs_s;
   logic              sclk_s;
   logic              sdi_s;
   logic              wr_en;
   logic [AW-1:0]     wr_addr;
   logic [BYTE_W-1:0] wr_data;
   logic [AW-1:0]     rd_addr;
   logic [BYTE_W-1:0] rd_data;
   logic              out_bit;
   logic              bidir_mode;

   cfg_sp_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, sdio_in}),
      .q     ({cs_s, sclk_s, sdi_s})
   );

   cfg_sp_engine #(
      .CNT_W (CNT_W),
      .AW    (AW)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_s       (cs_s),
      .sclk_s     (sclk_s),
      .sdi_s      (sdi_s),
      .ctl_bidir  (cfg_q[CTL_BIDIR]),
      .ctl_lsb    (cfg_q[CTL_LSB]),
      .rd_data    (rd_data),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .out_bit    (out_bit),
      .oe         (sdio_oe),
      .bidir_mode (bidir_mode)
   );

   cfg_sp_regbank #(
      .AW (AW)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .bank    (cfg_q)
   );

   assign sdio_out = bidir_mode ? out_bit : 1'b0;
   assign sdo      = bidir_mode ? 1'b0 : out_bit;
endmodule

// File: tb/tb_cfg_serial_port.sv
module tb_cfg_serial_port;
   localparam int H = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n = 1'b1;
   logic         sclk = 1'b0;
   logic         sdio_in = 1'b0;
   logic         sdio_out;
   logic         sdio_oe;
   logic         sdo;
   logic [255:0] cfg_q;

   int n_chk = 0, n_fail = 0;
   int n_cmp = 0, n_cmp_fail = 0;
   int cyc = 0, last_rise = 0;
   bit cmp_on = 0;

   logic [7:0] mreg [32];
   bit m_lsb = 0, m_bidir = 0;

   always #10 clk = ~clk;

   cfg_serial_port dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
      .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo), .cfg_q(cfg_q)
   );

   function automatic logic [255:0] model_flat();
      logic [255:0] f;
      for (int i = 0; i < 32; i++) f[i*8 +: 8] = mreg[i];
      return f;
   endfunction

   // per-clock comparison of the bank against the model (R3, R4, R5, R10, R11)
   always @(negedge clk) begin
      cyc = cyc + 1;
      if (cmp_on && rst_n && (cyc - last_rise) > 8) begin
         n_cmp = n_cmp + 1;
         if (cfg_q !== model_flat()) begin
            n_cmp_fail = n_cmp_fail + 1;
            $display("FAIL R3 bank at cycle %0d: actual %h expected %h", cyc, cfg_q, model_flat());
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic bit_cycle(input logic din, output logic dout, output bit pins_ok);
      sdio_in = din;
      repeat (H) @(negedge clk);
      dout    = m_bidir ? sdio_out : sdo;
      pins_ok = m_bidir ? (sdio_oe === 1'b1 && sdo === 1'b0)
                        : (sdio_oe === 1'b0 && sdio_out === 1'b0);
      sclk = 1'b1;
      last_rise = cyc;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
   endtask

   task automatic xfer(input bit rd, input int cnt, input int addr, input int nsend,
                       input logic [31:0] wdata, input int extra_bits, input string req);
      logic [7:0] instr, b, rb;
      logic       d;
      bit         pok, allok;
      int         a, left;
      instr = {rd, 2'(cnt - 1), 5'(addr)};
      cs_n = 1'b0;
      repeat (H) @(negedge clk);
      for (int i = 0; i < 8; i++) bit_cycle(m_lsb ? instr[i] : instr[7-i], d, pok);
      a = addr;
      left = cnt;
      for (int k = 0; k < nsend; k++) begin
         b = rd ? 8'h00 : wdata[k*8 +: 8];
         rb = '0;
         allok = 1;
         for (int i = 0; i < 8; i++) begin
            bit_cycle(m_lsb ? b[i] : b[7-i], d, pok);
            if (m_lsb) rb[i] = d; else rb[7-i] = d;
            allok = allok & pok;
         end
         if (left > 0) begin
            if (rd) begin
               chk(rb === mreg[a], req, $sformatf("read byte addr %0d", a), rb, mreg[a]);
               chk(allok, m_bidir ? "R8" : "R7", "pin/enable usage during read", allok, 1);
            end else if (a == 0 && b[5]) begin
               for (int i = 0; i < 32; i++) mreg[i] = 8'h00;
            end else begin
               mreg[a] = (a == 0) ? (b & 8'hDF) : b;
            end
            a = m_lsb ? (a + 1) % 32 : (a + 31) % 32;
            left = left - 1;
         end
      end
      for (int i = 0; i < extra_bits; i++) bit_cycle(1'b1, d, pok);
      repeat (H) @(negedge clk);
      cs_n = 1'b1;
      repeat (H) @(negedge clk);
      chk(sdio_oe === 1'b0, "R8", "enable after chip select release", sdio_oe, 0);
      m_lsb = mreg[0][6];
      m_bidir = mreg[0][7];
      repeat (4) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) mreg[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(cfg_q === '0, "R1", "bank after reset", cfg_q[63:0], 0);
      chk(sdo === 1'b0 && sdio_out === 1'b0, "R1", "data outputs after reset", {sdo, sdio_out}, 0);
      chk(sdio_oe === 1'b0, "R1", "enable after reset", sdio_oe, 0);
      cmp_on = 1;

      // R2 R3 R4: MSB-first three-byte write at 5 -> 5,4,3
      xfer(0, 3, 5, 3, 32'h00_C3_5A_A5, 0, "R4");
      // R6 R7: read back in four-wire mode
      xfer(1, 3, 5, 3, 0, 0, "R6");
      // R4 wrap 0 -> 31
      xfer(0, 3, 1, 3, 32'h00_77_00_19, 0, "R4");
      xfer(1, 3, 1, 3, 0, 0, "R4");
      // R11 abort mid-byte: second byte discarded
      xfer(0, 2, 10, 1, 32'h0000_003C, 3, "R11");
      xfer(1, 2, 10, 2, 0, 0, "R11");
      // R11 bytes past the count ignored
      xfer(0, 1, 12, 2, 32'h0000_E781, 0, "R11");
      xfer(1, 2, 12, 2, 0, 0, "R11");
      // R9 set LSB order mid-transfer; next byte still goes to 31 (decrement)
      xfer(0, 2, 0, 2, 32'h0000_5A40, 0, "R9");
      chk(cfg_q[31*8 +: 8] === 8'h5A, "R9", "byte after mode write", cfg_q[31*8 +: 8], 8'h5A);
      chk(cfg_q[1*8 +: 8] === 8'h19, "R9", "neighbour untouched", cfg_q[1*8 +: 8], 8'h19);
      // R5 LSB-first increments and wraps 31 -> 0
      xfer(0, 3, 29, 3, 32'h00_B2_D4_0F, 0, "R5");
      xfer(0, 2, 31, 2, 32'h0000_4066, 0, "R5");
      xfer(1, 4, 28, 4, 0, 0, "R5");
      xfer(1, 2, 31, 2, 0, 0, "R6");
      // R8 three-wire mode, still LSB order
      xfer(0, 1, 0, 1, 32'h0000_00C0, 0, "R8");
      xfer(1, 2, 30, 2, 0, 0, "R8");
      // R8 three-wire with MSB order
      xfer(0, 1, 0, 1, 32'h0000_0080, 0, "R8");
      xfer(1, 3, 5, 3, 0, 0, "R8");
      // R10 soft reset clears bank and modes
      xfer(0, 1, 0, 1, 32'h0000_00E0, 0, "R10");
      chk(cfg_q === '0, "R10", "bank after soft reset", cfg_q[63:0], 0);
      xfer(1, 2, 5, 2, 0, 0, "R10");
      // R10 self-clearing bit reads back 0 while other bits stay
      xfer(0, 1, 0, 1, 32'h0000_0010, 0, "R10");
      chk(cfg_q[7:0] === 8'h10, "R10", "control register value", cfg_q[7:0], 8'h10);
      xfer(1, 1, 0, 1, 0, 0, "R10");

      n_chk = n_chk + n_cmp;
      n_fail = n_fail + n_cmp_fail;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail = n_fail + n_cmp_fail + 1;
      n_chk = n_chk + n_cmp + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule